// File: doc/BRIEF.md
# Streaming Systematic Reed-Solomon Encoder

This block encodes a stream of m-bit symbols into systematic Reed-Solomon codewords. A start pulse opens a codeword. Each information symbol presented while the enable is high is captured on the rising clock edge and appears unchanged on the output bus one register later. When the last information symbol has been taken, the remainder of the message divided by the generator polynomial is shifted out as R check symbols on the next R enabled edges. The remainder comes from a Galois-field linear feedback shift register.

The field polynomial, the symbol width, the maximum codeword length and check count, the exponent of the first generator root and the exponent step between roots are all compile-time parameters. The generator coefficients are computed during elaboration. With the variable option enabled, two input ports can shorten the codeword length and the check count at run time. A coefficient set is precomputed for every allowed check count. Holding the enable low freezes the whole encoder.

Top module: `rs_syst_enc`

## Requirements
- R1: On an enabled edge in the information phase, the symbol on `sym_in` is captured and appears on `sym_out` directly after that same edge.
- R2: After the K = N − R information symbols, the next R enabled edges output the check symbols, highest degree first. Every codeword c(x) = Σ sym_out[i]·x^(N−1−i) then evaluates to zero at α^(FIRST_ROOT + j·ROOT_STEP) for j = 0..R−1, where α is the root of FIELD_POLY (bit w set is the x^w term).
- R3: `start` high on an enabled edge begins a new codeword: that edge's `sym_in` is information symbol 0 and the check state is cleared. A start in the middle of a codeword abandons the old codeword.
- R4: While `en` is low, no state changes, `sym_out` holds its value, and `start`, `sym_in`, `cw_len` and `chk_cnt` are ignored.
- R5: During the check phase, the value on `sym_in` has no effect on the output.
- R6: When no codeword is in progress, an enabled edge without `start` drives `sym_out` to zero.
- R7: With VAR_EN=1, `cw_len` (N) and `chk_cnt` (R) are sampled only on the start edge and are held for the whole codeword. Changes on these ports later in the codeword have no effect.
- R8: The sampled values are clamped. N is forced into [R_MAX+1, N_MAX] and R into [R_MIN, R_MAX]. With VAR_EN=0, N = N_MAX and R = R_MAX.
- R9: Asserting `rst_n` low asynchronously clears `sym_out` to zero and returns the encoder to idle. Release is synchronized through two flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new codeword on an enabled edge |
| en | input | 1 | Clock enable; low freezes the encoder |
| sym_in | input | SYM_W | Information symbol |
| cw_len | input | $clog2(N_MAX+1) | Run-time codeword length N (variable option) |
| chk_cnt | input | $clog2(R_MAX+1) | Run-time check-symbol count R (variable option) |
| sym_out | output | SYM_W | Codeword symbol output |

## Verification
A corrupted check register or a wrong generator coefficient leaves the information symbols untouched. It shows up only in the check symbols, so it becomes visible at the end of the codeword as a non-zero syndrome at one or more generator roots. A symbol counter that is off by one moves the phase boundary. The last information symbol is then replaced by a check symbol, or an extra symbol is passed through, and the pass-through comparison or the syndromes fail within the same codeword. A lost stall or a start accepted while stalled shows on the very next sampled output, because the output either moves during the stall or restarts the codeword.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  localparam int GF_MAXW = 10;

  typedef logic [GF_MAXW-1:0] gf_t;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_DATA = 2'd1,
    MODE_PAR  = 2'd2
  } enc_mode_e;

  // Product of two field elements of width w, reduced by poly (bit w set).
  function automatic gf_t gf_mul(input gf_t a, input gf_t b, input int w,
                                 input logic [GF_MAXW:0] poly);
    logic [GF_MAXW:0] sh;
    gf_t              res;
    res = '0;
    sh  = {1'b0, a};
    for (int i = 0; i < GF_MAXW; i++) begin
      if (i < w) begin
        if (b[i]) res = res ^ sh[GF_MAXW-1:0];
        sh = sh << 1;
        if (sh[w]) sh = sh ^ poly;
      end
    end
    return res;
  endfunction

  // alpha raised to e, elaboration use only.
  function automatic gf_t gf_alpha_pow(input int e, input int w,
                                       input logic [GF_MAXW:0] poly);
    int  ord;
    int  k;
    gf_t v;
    ord = (1 << w) - 1;
    k   = e % ord;
    v   = gf_t'(1);
    for (int i = 0; i < k; i++) v = gf_mul(v, gf_t'(2), w, poly);
    return v;
  endfunction

endpackage

// File: rtl/rs_enc_coef_sel.sv
module rs_enc_coef_sel
  import rs_enc_pkg::*;
#(
  parameter int               SYM_W      = 4,
  parameter int               R_MAX      = 4,
  parameter int               R_MIN      = 2,
  parameter logic [GF_MAXW:0] FIELD_POLY = 11'h013,
  parameter int               FIRST_ROOT = 1,
  parameter int               ROOT_STEP  = 2,
  localparam int              RW         = $clog2(R_MAX + 1),
  localparam int              CV_W       = R_MAX * SYM_W
) (
  input  logic [RW-1:0]   r_sel,
  output logic [CV_W-1:0] coef
);

  localparam int NSET = R_MAX - R_MIN + 1;

  // Non-monic coefficients g[0..r-1], aligned so g[r-1] sits in the top slot.
  function automatic logic [CV_W-1:0] build_gen(input int r);
    gf_t              g [0:R_MAX];
    gf_t              root;
    logic [CV_W-1:0]  pk;
    for (int j = 0; j <= R_MAX; j++) g[j] = '0;
    g[0] = gf_t'(1);
    for (int i = 0; i < r; i++) begin
      root = gf_alpha_pow(FIRST_ROOT + i * ROOT_STEP, SYM_W, FIELD_POLY);
      for (int j = i + 1; j >= 1; j--)
        g[j] = g[j-1] ^ gf_mul(g[j], root, SYM_W, FIELD_POLY);
      g[0] = gf_mul(g[0], root, SYM_W, FIELD_POLY);
    end
    pk = '0;
    for (int j = 0; j < r; j++) pk[(R_MAX - r + j) * SYM_W +: SYM_W] = g[j][SYM_W-1:0];
    return pk;
  endfunction

  logic [CV_W-1:0] tbl [NSET];

  for (genvar gi = 0; gi < NSET; gi++) begin : g_set
    localparam logic [CV_W-1:0] SET_C = build_gen(R_MIN + gi);
    assign tbl[gi] = SET_C;
  end

  always_comb begin
    coef = tbl[NSET-1];
    for (int k = 0; k < NSET; k++) begin
      if (r_sel == RW'(R_MIN + k)) coef = tbl[k];
    end
  end

endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int  N_MAX  = 15,
  parameter int  R_MAX  = 4,
  parameter int  R_MIN  = 2,
  parameter bit  VAR_EN = 1'b1,
  localparam int CW     = $clog2(N_MAX + 1),
  localparam int RW     = $clog2(R_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic [CW-1:0] cw_len,
  input  logic [RW-1:0] chk_cnt,
  output enc_mode_e     mode,
  output logic [RW-1:0] r_sel
);

  localparam int N_MIN = R_MAX + 1;

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] n_q, n_n;
  logic [RW-1:0] r_q, r_n;
  logic [CW-1:0] n_clamp, n_in, k_q;
  logic [RW-1:0] r_clamp, r_in;

  always_comb begin
    if (cw_len < CW'(N_MIN))      n_clamp = CW'(N_MIN);
    else if (cw_len > CW'(N_MAX)) n_clamp = CW'(N_MAX);
    else                          n_clamp = cw_len;
    if (chk_cnt < RW'(R_MIN))      r_clamp = RW'(R_MIN);
    else if (chk_cnt > RW'(R_MAX)) r_clamp = RW'(R_MAX);
    else                           r_clamp = chk_cnt;
    n_in = VAR_EN ? n_clamp : CW'(N_MAX);
    r_in = VAR_EN ? r_clamp : RW'(R_MAX);
  end

  assign k_q   = n_q - CW'(r_q);
  assign r_sel = start ? r_in : r_q;

  always_comb begin
    if (start)            mode = MODE_DATA;
    else if (!busy_q)     mode = MODE_IDLE;
    else if (cnt_q < k_q) mode = MODE_DATA;
    else                  mode = MODE_PAR;
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    n_n    = n_q;
    r_n    = r_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CW'(1);
      n_n    = n_in;
      r_n    = r_in;
    end else if (busy_q) begin
      if (cnt_q + CW'(1) == n_q) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      n_q    <= CW'(N_MAX);
      r_q    <= RW'(R_MAX);
    end else if (en) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      n_q    <= n_n;
      r_q    <= r_n;
    end
  end

  // R2: position stays inside the codeword
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q >= CW'(1)) && (cnt_q < n_q));

  // R3: an accepted start restarts the count at one
  assert_start_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start) |=> (busy_q && cnt_q == CW'(1)));

  // R7: lengths do not move inside a codeword
  assert_len_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(en && start)) |=> (n_q == $past(n_q)) && (r_q == $past(r_q)));

  // R8: latched lengths within their clamps
  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (n_q >= CW'(N_MIN)) && (n_q <= CW'(N_MAX)) &&
               (r_q >= RW'(R_MIN)) && (r_q <= RW'(R_MAX)));

endmodule

// File: rtl/rs_enc_lfsr.sv
module rs_enc_lfsr
  import rs_enc_pkg::*;
#(
  parameter int               SYM_W      = 4,
  parameter int               R_MAX      = 4,
  parameter logic [GF_MAXW:0] FIELD_POLY = 11'h013,
  localparam int              CV_W       = R_MAX * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  enc_mode_e        mode,
  input  logic [SYM_W-1:0] din,
  input  logic [CV_W-1:0]  coef,
  output logic [SYM_W-1:0] par_top
);

  logic [R_MAX-1:0][SYM_W-1:0] p_q, p_n, base;
  logic [SYM_W-1:0]            fb;

  function automatic logic [SYM_W-1:0] mulw(input logic [SYM_W-1:0] a,
                                            input logic [SYM_W-1:0] b);
    gf_t t;
    t = gf_mul(gf_t'(a), gf_t'(b), SYM_W, FIELD_POLY);
    return t[SYM_W-1:0];
  endfunction

  always_comb begin
    for (int j = 0; j < R_MAX; j++) base[j] = clr ? '0 : p_q[j];
    fb  = (mode == MODE_DATA) ? (din ^ base[R_MAX-1]) : '0;
    p_n = p_q;
    case (mode)
      MODE_DATA: begin
        p_n[0] = mulw(fb, coef[0 +: SYM_W]);
        for (int j = 1; j < R_MAX; j++)
          p_n[j] = base[j-1] ^ mulw(fb, coef[j*SYM_W +: SYM_W]);
      end
      MODE_PAR: begin
        p_n[0] = '0;
        for (int j = 1; j < R_MAX; j++) p_n[j] = p_q[j-1];
      end
      default: p_n = p_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  p_q <= '0;
    else if (en) p_q <= p_n;
  end

  assign par_top = p_q[R_MAX-1];

  if (R_MAX > 1) begin : g_chk
    // R2: check symbols leave in order, one register per enabled edge
    assert_par_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == MODE_PAR) |=> (p_q[R_MAX-1] == $past(p_q[R_MAX-2])));
  end

  // R4: nothing moves while stalled
  assert_par_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(p_q));

endmodule

// File: rtl/rs_syst_enc.sv
module rs_syst_enc
  import rs_enc_pkg::*;
#(
  parameter int               SYM_W      = 4,
  parameter int               N_MAX      = 15,
  parameter int               R_MAX      = 4,
  parameter int               R_MIN      = 2,
  parameter logic [GF_MAXW:0] FIELD_POLY = 11'h013,
  parameter int               FIRST_ROOT = 1,
  parameter int               ROOT_STEP  = 2,
  parameter bit               VAR_EN     = 1'b1,
  localparam int              CW         = $clog2(N_MAX + 1),
  localparam int              RW         = $clog2(R_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic [SYM_W-1:0] sym_in,
  input  logic [CW-1:0]    cw_len,
  input  logic [RW-1:0]    chk_cnt,
  output logic [SYM_W-1:0] sym_out
);

  localparam int CV_W = R_MAX * SYM_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  enc_mode_e        mode;
  logic [RW-1:0]    r_sel;
  logic [CV_W-1:0]  coef;
  logic [SYM_W-1:0] par_top;
  logic [SYM_W-1:0] out_q, out_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rs_enc_ctrl #(
    .N_MAX(N_MAX), .R_MAX(R_MAX), .R_MIN(R_MIN), .VAR_EN(VAR_EN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .en(en), .start(start),
    .cw_len(cw_len), .chk_cnt(chk_cnt), .mode(mode), .r_sel(r_sel)
  );

  rs_enc_coef_sel #(
    .SYM_W(SYM_W), .R_MAX(R_MAX), .R_MIN(R_MIN), .FIELD_POLY(FIELD_POLY),
    .FIRST_ROOT(FIRST_ROOT), .ROOT_STEP(ROOT_STEP)
  ) coef_i (
    .r_sel(r_sel), .coef(coef)
  );

  rs_enc_lfsr #(
    .SYM_W(SYM_W), .R_MAX(R_MAX), .FIELD_POLY(FIELD_POLY)
  ) lfsr_i (
    .clk(clk), .rst_n(rst_int_n), .en(en), .clr(start), .mode(mode),
    .din(sym_in), .coef(coef), .par_top(par_top)
  );

  always_comb begin
    case (mode)
      MODE_DATA: out_n = sym_in;
      MODE_PAR:  out_n = par_top;
      default:   out_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (!rst_int_n) out_q <= '0;
    else if (en)      out_q <= out_n;
  end

  assign sym_out = out_q;

  // R1: information symbols pass through with one register
  assert_data_pass_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && mode == MODE_DATA) |=> (sym_out == $past(sym_in)));

  // R4: output frozen while stalled
  assert_hold_stall_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> $stable(sym_out));

  // R6: idle output is zero
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && mode == MODE_IDLE) |=> (sym_out == '0));

  // R9: output cleared while held in reset
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |-> (sym_out == '0));

endmodule

// File: tb/rs_syst_enc_tb.sv
`timescale 1ns/1ps
module rs_syst_enc_tb_top;

  localparam int          W          = 4;
  localparam int          N_MAX      = 15;
  localparam int          R_MAX      = 4;
  localparam int          R_MIN      = 2;
  localparam logic [10:0] POLY       = 11'h013;
  localparam int          FIRST_ROOT = 1;
  localparam int          ROOT_STEP  = 2;
  localparam int          CW         = $clog2(N_MAX + 1);
  localparam int          RW         = $clog2(R_MAX + 1);
  localparam int          ORD        = (1 << W) - 1;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          en;
  logic [W-1:0]  sym_in;
  logic [CW-1:0] cw_len;
  logic [RW-1:0] chk_cnt;
  logic [W-1:0]  sym_out;

  int n_tests;
  int n_fail;
  int exp_t [0:ORD-1];
  int log_t [0:ORD];

  rs_syst_enc #(
    .SYM_W(W), .N_MAX(N_MAX), .R_MAX(R_MAX), .R_MIN(R_MIN), .FIELD_POLY(POLY),
    .FIRST_ROOT(FIRST_ROOT), .ROOT_STEP(ROOT_STEP), .VAR_EN(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en), .sym_in(sym_in),
    .cw_len(cw_len), .chk_cnt(chk_cnt), .sym_out(sym_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % ORD];
  endfunction

  task automatic build_tables();
    int v;
    v = 1;
    for (int i = 0; i < ORD; i++) begin
      exp_t[i] = v;
      log_t[v] = i;
      v = v << 1;
      if (v & (1 << W)) v = v ^ int'(POLY);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Full codeword with optional stalls; lengths randomized after the start edge.
  task automatic run_word(input int raw_n, input int raw_r, input int stall_gap, input string tag);
    logic [W-1:0] info [N_MAX];
    logic [W-1:0] cw   [N_MAX];
    logic [W-1:0] held;
    int n_e, r_e, k_e, s, a, miss;
    n_e = clampi(raw_n, R_MAX + 1, N_MAX);
    r_e = clampi(raw_r, R_MIN, R_MAX);
    k_e = n_e - r_e;
    for (int i = 0; i < N_MAX; i++) info[i] = W'($urandom);
    for (int i = 0; i < n_e; i++) begin
      if (stall_gap > 0 && i > 0 && (i % stall_gap) == 0) begin
        @(negedge clk);
        held    = sym_out;
        en      = 1'b0;
        start   = 1'b1;
        sym_in  = W'($urandom);
        cw_len  = CW'($urandom);
        chk_cnt = RW'($urandom);
        @(negedge clk);
        start  = 1'b0;
        sym_in = W'($urandom);
        @(negedge clk);
        chk(sym_out == held, {tag, " R4 stall hold"}, int'(sym_out), int'(held));
      end
      @(negedge clk);
      en      = 1'b1;
      start   = (i == 0);
      sym_in  = (i < k_e) ? info[i] : W'($urandom);
      cw_len  = (i == 0) ? CW'(raw_n) : CW'($urandom);
      chk_cnt = (i == 0) ? RW'(raw_r) : RW'($urandom);
      @(posedge clk);
      #1;
      cw[i] = sym_out;
    end
    @(negedge clk);
    en    = 1'b0;
    start = 1'b0;
    miss = 0;
    for (int i = 0; i < k_e; i++) if (cw[i] != info[i]) miss++;
    chk(miss == 0, {tag, " R1 pass-through mismatches"}, miss, 0);
    for (int j = 0; j < r_e; j++) begin
      a = exp_t[(FIRST_ROOT + j * ROOT_STEP) % ORD];
      s = 0;
      for (int i = 0; i < n_e; i++) s = gmul(s, a) ^ int'(cw[i]);
      chk(s == 0, {tag, " R2 R5 R7 syndrome"}, s, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; en = 1'b0; sym_in = '0; cw_len = '0; chk_cnt = '0;
    repeat (3) @(negedge clk);
    chk(sym_out == '0, "R9 output at reset", int'(sym_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle();
    for (int e = 0; e < 2; e++) begin
      @(negedge clk);
      en = 1'b1; start = 1'b0; sym_in = W'($urandom | 1);
      @(posedge clk);
      #1;
      chk(sym_out == '0, "R6 idle output", int'(sym_out), 0);
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic t_restart();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      en = 1'b1; start = (i == 0); sym_in = W'($urandom);
      cw_len = CW'(N_MAX); chk_cnt = RW'(R_MAX);
      @(posedge clk);
    end
    run_word(N_MAX, R_MAX, 0, "R3 restart");
  endtask

  task automatic t_async_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      en = 1'b1; start = (i == 0); sym_in = W'($urandom | 1);
      cw_len = CW'(N_MAX); chk_cnt = RW'(R_MAX);
      @(posedge clk);
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sym_out == '0, "R9 async clear", int'(sym_out), 0);
    en = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b1; sym_in = W'($urandom | 1);
    @(posedge clk);
    #1;
    chk(sym_out == '0, "R9 idle after reset", int'(sym_out), 0);
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    build_tables();
    t_reset();
    run_word(N_MAX, R_MAX, 0, "full");
    t_idle();
    run_word(N_MAX, R_MAX, 3, "stalled");
    run_word(9, 2, 0, "var 9/2");
    run_word(12, 3, 4, "var 12/3");
    run_word(2, 7, 0, "R8 clamp low n high r");
    run_word(N_MAX, 0, 0, "R8 clamp low r");
    t_restart();
    t_async_reset();
    run_word(N_MAX, R_MAX, 2, "after reset");
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule